// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Modem Control

This block sends characters over one asynchronous serial line. A host writes a byte into a one-byte holding buffer. When the shifter is free and transmission is allowed, the byte moves into the shifter. The shifter then sends a start bit, five to eight data bits least significant first, an optional parity bit, and one or two stop bits. Bit timing comes from a separate transmit clock running at 1, 16, 32 or 64 times the bit rate. The line changes only on falling edges of that clock.

Around the shifter sits a small modem-control section:
- It drives the request-to-send pin. The pin goes active at once when commanded. When the command is withdrawn, the pin is released only after the line has fully drained.
- It synchronises the clear-to-send input. When auto-enable is set, a character may start only while clear-to-send is low.
- It raises a one-cycle change pulse for every edge seen on clear-to-send.

Everything runs in the system clock domain with a synchronous active-high reset. The transmit clock is sampled in that domain.

Top module: `sertx_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `txd`=1, `rts_n`=1, `tx_empty`=1, `all_sent`=1 and `cts_chg`=0. Whenever `all_sent` is 1, `txd` is 1.
- R2: The frame format is as follows:
  - a start bit of 0;
  - the data bits, least significant first, with the count set by `clen` (0=5, 1=6, 2=7, 3=8);
  - when `par_en`=1, a parity bit that makes the count of ones over data and parity even (`par_odd`=0) or odd (`par_odd`=1);
  - one stop bit of 1, or two when `stop2`=1.
- R3: Each bit lasts N falling edges of `txc`, with `mult` 0/1/2/3 selecting N = 1/16/32/64. `txd` changes only on the system clock edge that first samples `txc` low after it was high.
- R4: Writing to the holding buffer:
  - a `wr_stb` while `tx_empty`=1 loads `wr_data` and clears `tx_empty` on the next clock;
  - `tx_empty` returns to 1 on the same clock on which the start bit of that byte appears on `txd`;
  - a `wr_stb` while `tx_empty`=0 is ignored.
- R5: A byte waiting in the buffer starts its start bit at the `txc` fall that ends the last stop bit of the previous character, with no idle time between the two characters.
- R6: `all_sent` falls when a byte is accepted. It rises only once the last stop bit of the last character has ended and the buffer is empty.
- R7: While `tx_en`=0 no character starts and `txd` stays 1.
- R8: While `auto_en`=1 and the synchronised `cts_n` is high, no character starts. A character already under way finishes unchanged.
- R9: `rts_cmd`=1 drives `rts_n` low on the next clock. After `rts_cmd` returns to 0, `rts_n` stays low until `all_sent` is 1, and then goes high on the next clock.
- R10: Each rising or falling edge of `cts_n` gives exactly one single-cycle pulse on `cts_chg`, three clocks later. This holds whatever the value of `auto_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc | input | 1 | Transmit clock, synchronous to clk |
| tx_en | input | 1 | Transmitter enable |
| mult | input | 2 | Clock multiplier select (1/16/32/64) |
| clen | input | 2 | Character length select (5..8) |
| stop2 | input | 1 | Two stop bits when 1 |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| auto_en | input | 1 | Gate character start by clear-to-send |
| rts_cmd | input | 1 | Request-to-send command bit |
| cts_n | input | 1 | Clear-to-send pin, active low |
| wr_data | input | 8 | Byte to transmit |
| wr_stb | input | 1 | Load strobe for wr_data |
| txd | output | 1 | Serial data out, idle high |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_empty | output | 1 | Holding buffer empty |
| all_sent | output | 1 | Buffer and shifter both empty |
| cts_chg | output | 1 | One-cycle pulse on any clear-to-send edge |

## Verification
The assertions rely on the following conditions at the inputs:
- `txc` is synchronous to `clk` and stays in each level for at least one clock.
- The format inputs (`clen`, `par_en`, `par_odd`, `stop2`, `mult`) change only while `all_sent` is 1.
- `rts_cmd` is low during reset.

The stimulus keeps within these conditions:
- It derives `txc` from a divider clocked on the falling edge of `clk`, at four system clocks per period.
- It reconfigures only after waiting for the line to drain.
- It moves `cts_n` far apart, so every change pulse can be counted separately.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int DIV_W   = 6;

    typedef enum logic [1:0] {
        MUL_X1  = 2'd0,
        MUL_X16 = 2'd1,
        MUL_X32 = 2'd2,
        MUL_X64 = 2'd3
    } mul_e;

    typedef enum logic [1:0] {
        LEN_5 = 2'd0,
        LEN_6 = 2'd1,
        LEN_7 = 2'd2,
        LEN_8 = 2'd3
    } len_e;

    typedef struct packed {
        len_e len;
        logic stop2;
        logic par_en;
        logic par_odd;
    } fmt_t;

    function automatic logic [DIV_W-1:0] div_last(mul_e m);
        case (m)
            MUL_X1:  return DIV_W'(0);
            MUL_X16: return DIV_W'(15);
            MUL_X32: return DIV_W'(31);
            default: return DIV_W'(63);
        endcase
    endfunction

    function automatic int unsigned data_bits(len_e l);
        return 5 + int'(l);
    endfunction

    // Bits after the start bit: data, parity, then stop ones (fill)
    function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
        logic [FRAME_W-1:0] v;
        logic               p;
        int unsigned        nb;
        nb = data_bits(f.len);
        v  = '1;
        p  = f.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nb) begin
                v[i] = d[i];
                p    = p ^ d[i];
            end
        end
        if (f.par_en) v[nb] = p;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] frame_rem(fmt_t f);
        return CNT_W'(data_bits(f.len) + 32'(f.par_en) + 1 + 32'(f.stop2));
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud
    import sertx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic txc,
    input  logic run,
    input  mul_e mul,
    output logic fall,
    output logic bit_end
);
    logic             txc_q;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last    = div_last(mul);
    assign fall    = txc_q & ~txc;
    assign bit_end = run & fall & (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_q <= 1'b1;
            cnt   <= '0;
        end else begin
            txc_q <= txc;
            if (!run)
                cnt <= '0;
            else if (fall)
                cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= last));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              bit_end,
    input  logic              tx_en,
    input  logic              gate_ok,
    input  fmt_t              fmt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stb,
    output logic              txd,
    output logic              busy,
    output logic              tx_empty,
    output logic              all_sent
);
    logic [DATA_W-1:0]  buf_q;
    logic               buf_full;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   rem;
    logic               slot;
    logic               launch;

    assign slot     = busy ? (bit_end && rem == '0) : fall;
    assign launch   = slot & buf_full & tx_en & gate_ok;
    assign tx_empty = ~buf_full;
    assign all_sent = ~buf_full & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            sh       <= '1;
            rem      <= '0;
            busy     <= 1'b0;
            txd      <= 1'b1;
        end else begin
            if (launch) begin
                sh       <= build_frame(buf_q, fmt);
                rem      <= frame_rem(fmt);
                busy     <= 1'b1;
                txd      <= 1'b0;
                buf_full <= 1'b0;
            end else if (busy && bit_end) begin
                if (rem == '0) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    txd <= sh[0];
                    sh  <= {1'b1, sh[FRAME_W-1:1]};
                    rem <= rem - 1'b1;
                end
            end
            if (wr_stb && !buf_full) begin
                buf_q    <= wr_data;
                buf_full <= 1'b1;
            end
        end
    end

    // R3
    txd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(txd));
    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !launch) |=> $stable(buf_q));
    // R7
    start_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_en));
    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gate_ok));
endmodule

// File: rtl/sertx_modem.sv
module sertx_modem (
    input  logic clk,
    input  logic rst,
    input  logic cts_n,
    input  logic auto_en,
    input  logic rts_cmd,
    input  logic all_sent,
    output logic gate_ok,
    output logic rts_n,
    output logic cts_chg
);
    logic [2:0] cts_s;

    assign gate_ok = ~auto_en | ~cts_s[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_s   <= 3'b111;
            cts_chg <= 1'b0;
            rts_n   <= 1'b1;
        end else begin
            cts_s   <= {cts_s[1:0], cts_n};
            cts_chg <= cts_s[1] ^ cts_s[2];
            if (rts_cmd)
                rts_n <= 1'b0;
            else if (all_sent)
                rts_n <= 1'b1;
        end
    end

    // R9
    rts_on_chk: assert property (@(posedge clk) disable iff (rst)
        rts_cmd |=> !rts_n);
    // R9
    rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rts_n && !all_sent) |=> !rts_n);
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              txc,
    input  logic              tx_en,
    input  logic [1:0]        mult,
    input  logic [1:0]        clen,
    input  logic              stop2,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              auto_en,
    input  logic              rts_cmd,
    input  logic              cts_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_stb,
    output logic              txd,
    output logic              rts_n,
    output logic              tx_empty,
    output logic              all_sent,
    output logic              cts_chg
);
    fmt_t fmt;
    logic fall, bit_end, busy, gate_ok;

    assign fmt.len     = len_e'(clen);
    assign fmt.stop2   = stop2;
    assign fmt.par_en  = par_en;
    assign fmt.par_odd = par_odd;

    sertx_baud u_baud (
        .clk(clk), .rst(rst), .txc(txc), .run(busy), .mul(mul_e'(mult)),
        .fall(fall), .bit_end(bit_end)
    );

    sertx_shift u_shift (
        .clk(clk), .rst(rst), .fall(fall), .bit_end(bit_end), .tx_en(tx_en),
        .gate_ok(gate_ok), .fmt(fmt), .wr_data(wr_data), .wr_stb(wr_stb),
        .txd(txd), .busy(busy), .tx_empty(tx_empty), .all_sent(all_sent)
    );

    sertx_modem u_modem (
        .clk(clk), .rst(rst), .cts_n(cts_n), .auto_en(auto_en),
        .rts_cmd(rts_cmd), .all_sent(all_sent), .gate_ok(gate_ok),
        .rts_n(rts_n), .cts_chg(cts_chg)
    );

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> txd);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txc = 1'b1;
    logic tx_en = 1'b1;
    logic [1:0] mult = 2'd1;
    logic [1:0] clen = 2'd3;
    logic stop2 = 1'b0, par_en = 1'b0, par_odd = 1'b0, auto_en = 1'b0;
    logic rts_cmd = 1'b0, cts_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic wr_stb = 1'b0;
    logic txd, rts_n, tx_empty, all_sent, cts_chg;

    typedef struct {
        logic [7:0] d;
        int nb;
        bit pe, po, s2;
        int div;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    bit mon_busy = 0;
    bit finished = 0;
    int chg_cnt = 0;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst(rst), .txc(txc), .tx_en(tx_en), .mult(mult), .clen(clen),
        .stop2(stop2), .par_en(par_en), .par_odd(par_odd), .auto_en(auto_en),
        .rts_cmd(rts_cmd), .cts_n(cts_n), .wr_data(wr_data), .wr_stb(wr_stb),
        .txd(txd), .rts_n(rts_n), .tx_empty(tx_empty), .all_sent(all_sent),
        .cts_chg(cts_chg)
    );

    // txc: period of four system clocks, changed away from the active edge
    always @(negedge clk) begin
        tdiv <= (tdiv + 1) % 2;
        if (tdiv == 1) txc <= ~txc;
    end

    always @(negedge clk) if (!rst && cts_chg === 1'b1) chg_cnt <= chg_cnt + 1;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int mdiv(logic [1:0] m);
        case (m)
            2'd0: return 1;
            2'd1: return 16;
            2'd2: return 32;
            default: return 64;
        endcase
    endfunction

    // Expected bits after the start bit, first bit in position 0
    function automatic logic [11:0] exp_bits(item_t it, output int n);
        logic [11:0] v = '0;
        int ones = 0;
        n = 0;
        for (int i = 0; i < it.nb; i++) begin
            v[n] = it.d[i];
            ones += it.d[i];
            n++;
        end
        if (it.pe) begin
            v[n] = it.po ? ((ones % 2) == 0) : ((ones % 2) == 1);
            n++;
        end
        v[n] = 1'b1; n++;
        if (it.s2) begin v[n] = 1'b1; n++; end
        return v;
    endfunction

    task automatic write_byte(logic [7:0] d, bit expect_take);
        item_t it;
        it.d = d; it.nb = 5 + int'(clen); it.pe = par_en; it.po = par_odd;
        it.s2 = stop2; it.div = mdiv(mult);
        if (expect_take) q.push_back(it);
        @(negedge clk);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_drain(string tag);
        int k = 0;
        while (!(all_sent === 1'b1 && q.size() == 0 && !mon_busy) && k < 40000) begin
            @(negedge clk);
            k++;
            if (all_sent === 1'b1 && mon_busy && q.size() == 0)
                chk(0, tag, "all_sent before last stop bit", 1, 0);
        end
        chk(k < 40000, tag, "drain timeout", k, 0);
    endtask

    task automatic wait_start();
        int k = 0;
        while (txd !== 1'b0 && k < 40000) begin @(negedge clk); k++; end
    endtask

    // Monitor: decode each frame and compare with the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                if (q.size() == 0) begin
                    chk(0, "R7", "unexpected start bit", 0, 1);
                    while (txd === 1'b0) @(negedge clk);
                end else begin
                    item_t it;
                    int n, bc, nerr;
                    logic [11:0] e, g;
                    mon_busy = 1;
                    it = q.pop_front();
                    bc = it.div * 4;
                    e = exp_bits(it, n);
                    g = '0;
                    repeat (bc / 2) @(negedge clk);
                    nerr = (txd !== 1'b0);
                    for (int i = 0; i < n; i++) begin
                        repeat (bc) @(negedge clk);
                        g[i] = txd;
                    end
                    chk(nerr == 0 && g == e, "R2 R3 R5", "frame bits", int'(g), int'(e));
                    mon_busy = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(txd === 1 && rts_n === 1 && tx_empty === 1 && all_sent === 1 && cts_chg === 0,
            "R1", "reset outputs", {txd, rts_n, tx_empty, all_sent, cts_chg}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1 && rts_n === 1 && tx_empty === 1 && all_sent === 1 && cts_chg === 0,
            "R1", "after reset", {txd, rts_n, tx_empty, all_sent, cts_chg}, 5'b11110);

        // 8N1 x16, R4 R6 accept
        write_byte(8'hA5, 1);
        chk(tx_empty === 1'b0, "R4", "tx_empty after write", tx_empty, 0);
        chk(all_sent === 1'b0, "R6", "all_sent after write", all_sent, 1'b0);
        wait_start();
        chk(tx_empty === 1'b1, "R4", "tx_empty at start bit", tx_empty, 1);
        wait_drain("R6");

        // 7E1 x1; back-to-back plus ignored third write (R4 R5)
        mult = 2'd0; clen = 2'd2; par_en = 1; par_odd = 0;
        write_byte(8'h3B, 1);
        wait_start();
        write_byte(8'h46, 1);
        write_byte(8'hFF, 0);
        wait_drain("R5");
        repeat (200) @(negedge clk);
        chk(txd === 1'b1 && all_sent === 1'b1, "R4", "ignored write sent nothing", txd, 1);

        // 5O2 x32
        mult = 2'd2; clen = 2'd0; par_odd = 1; stop2 = 1;
        write_byte(8'h13, 1);
        wait_drain("R2");

        // 6N2 x64
        mult = 2'd3; clen = 2'd1; par_en = 0;
        write_byte(8'h2D, 1);
        wait_drain("R3");

        // 8 odd parity x16, 1 stop
        mult = 2'd1; clen = 2'd3; par_en = 1; par_odd = 1; stop2 = 0;
        write_byte(8'h80, 1);
        wait_drain("R2");

        // R7 transmitter disabled
        par_en = 0; tx_en = 0;
        write_byte(8'h5A, 1);
        repeat (300) @(negedge clk);
        chk(txd === 1'b1 && all_sent === 1'b0, "R7", "held while disabled", txd, 1);
        tx_en = 1;
        wait_drain("R7");

        // R8 auto-enable gating
        auto_en = 1; cts_n = 1;
        write_byte(8'hC3, 1);
        repeat (300) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b0, "R8", "held while cts high", tx_empty, 0);
        cts_n = 0;
        wait_start();
        cts_n = 1;
        write_byte(8'h7E, 1);
        repeat (1000) @(negedge clk);
        chk(mon_busy == 0 && q.size() == 1, "R8", "current char finished, next held", q.size(), 1);
        chk(txd === 1'b1 && tx_empty === 1'b0, "R8", "second char held", tx_empty, 0);
        cts_n = 0;
        wait_drain("R8");
        auto_en = 0;

        // R9 request-to-send
        @(negedge clk); rts_cmd = 1;
        @(negedge clk);
        chk(rts_n === 1'b0, "R9", "rts_n low after command", rts_n, 0);
        write_byte(8'h99, 1);
        rts_cmd = 0;
        repeat (100) @(negedge clk);
        chk(rts_n === 1'b0, "R9", "rts_n held mid character", rts_n, 0);
        wait_drain("R9");
        @(negedge clk);
        chk(rts_n === 1'b1, "R9", "rts_n released after drain", rts_n, 1);

        // R10 change pulses on both edges
        repeat (20) @(negedge clk);
        c0 = chg_cnt; cts_n = 1;
        repeat (20) @(negedge clk);
        chk(chg_cnt - c0 == 1, "R10", "pulses on rising edge", chg_cnt - c0, 1);
        c0 = chg_cnt; cts_n = 0;
        repeat (20) @(negedge clk);
        chk(chg_cnt - c0 == 1, "R10", "pulses on falling edge", chg_cnt - c0, 1);
        auto_en = 1;
        c0 = chg_cnt; cts_n = 1;
        repeat (20) @(negedge clk);
        chk(chg_cnt - c0 == 1, "R10", "pulse with auto-enable", chg_cnt - c0, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule